// File: doc/BRIEF.md
# Trap Vector Address Generator

This block holds the machine trap-vector base register and turns every trap into a redirect target for the program counter. Each trap arrives as a one-cycle request with an interrupt flag and a cause number. The block answers with a one-cycle target-valid pulse and the target address. The two low bits of the base register choose how the target is formed:

- single-entry mode sends every trap to the base address;
- jump-table mode sends interrupts to a slot four bytes per cause above the base;
- pointer-table mode fetches the handler address from memory.

In pointer-table mode a per-interrupt bitmap register decides whether an interrupt uses its own table slot or the shared slot 0. For that fetch the block issues one read request, waits for the response and only then presents the target. The read data has its lowest bit cleared before it is used. A bus error sends the trap to the base address.

Software discovers what the block supports by writing a value and reading it back. A mode that is not supported is never stored. A base that the configuration fixes ignores writes and always reads back its fixed value. While a pointer fetch is outstanding the block reports busy, and any new trap request is ignored.

Top module: `trap_vec_gen`

## Requirements
- R1: After reset, the base register reads `BASE_RESET` with mode bits 00, the bitmap reads 0, and `tgt_valid` and `mem_req` are low.
- R2: A write to the base register (`csr_sel`=0) stores bits [31:2] as the base. A read returns {base[31:2], mode[1:0]}.
- R3: In mode 00, every trap, whether synchronous or interrupt, produces `tgt_valid` one cycle after `trap_req` is sampled, with `tgt_pc` equal to the base.
- R4: In mode 01, a synchronous trap targets the base. An interrupt with cause n targets base + 4·n. Timing is the same as in R3.
- R5: A write whose mode bits are 10, or name a mode the configuration does not support, leaves the stored mode unchanged. The base field is still updated.
- R6: In mode 11, an interrupt raises `mem_req` for exactly one cycle, one cycle after the trap. If bitmap bit n is 1, `mem_addr` is base + 4·n; if it is 0, `mem_addr` is the base (slot 0).
- R7: In mode 11, `tgt_valid` rises one cycle after `mem_rsp_valid` is sampled without error, with `tgt_pc` equal to `mem_rsp_data` with bit 0 cleared. No target appears before the response.
- R8: In mode 11, a response with `mem_rsp_err`=1 yields `tgt_pc` equal to the base.
- R9: In mode 11, a synchronous trap targets the base one cycle after the trap, with no memory request.
- R10: With `FIXED_BASE`=1, writes to the base field are ignored and `BASE_RESET` reads back. Mode writes still follow R5.
- R11: While `busy` is high, `trap_req` is ignored: it causes no request and no target.
- R12: The bitmap register (`csr_sel`=1) stores bits [NUM_IRQ-1:0] of the write data; higher bits read as 0. Without table support it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 selects the base register, 1 selects the bitmap |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the selected register |
| trap_req | input | 1 | One-cycle trap event |
| trap_is_irq | input | 1 | 1 for an interrupt, 0 for a synchronous exception |
| trap_cause | input | $clog2(NUM_IRQ) | Cause or interrupt number |
| busy | output | 1 | Pointer fetch outstanding |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | 32 | Table read address |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 32 | Read response data |
| mem_rsp_err | input | 1 | Read response bus error |
| tgt_valid | output | 1 | Target valid pulse |
| tgt_pc | output | 32 | Redirect target |

## Verification
Traps are driven in every stored mode with both synchronous and interrupt flags. This separates the mode decode from the interrupt-flag decode.

Interrupt causes 0, 9 and 15 are used to check the slot offset at both ends of the cause range. In pointer-table mode, causes with bitmap bits set and cleared separate the individual slot from the shared slot. Clean, error and delayed responses, with stray traps injected while the fetch is outstanding, check that the target follows the response and not the trap.

Capability discovery is exercised through reserved and unsupported mode writes, and through a second instance with a fixed base and reduced mode support.

// File: rtl/trap_vec_gen.sv
module trap_vec_gen #(
  parameter int          NUM_IRQ    = 16,
  parameter bit          SUP_DIRECT = 1'b1,
  parameter bit          SUP_VEC    = 1'b1,
  parameter bit          SUP_TABLE  = 1'b1,
  parameter bit          FIXED_BASE = 1'b0,
  parameter logic [31:0] BASE_RESET = 32'h0000_1000,
  parameter logic [1:0]  RESET_MODE = 2'b00
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       csr_we,
  input  logic                       csr_sel,
  input  logic [31:0]                csr_wdata,
  output logic [31:0]                csr_rdata,
  input  logic                       trap_req,
  input  logic                       trap_is_irq,
  input  logic [$clog2(NUM_IRQ)-1:0] trap_cause,
  output logic                       busy,
  output logic                       mem_req,
  output logic [31:0]                mem_addr,
  input  logic                       mem_rsp_valid,
  input  logic [31:0]                mem_rsp_data,
  input  logic                       mem_rsp_err,
  output logic                       tgt_valid,
  output logic [31:0]                tgt_pc
);
  localparam int CW = $clog2(NUM_IRQ);
  localparam logic [3:0] MODE_OK = {SUP_TABLE, 1'b0, SUP_VEC, SUP_DIRECT};

  logic [31:2]        base_q;
  logic [1:0]         mode_q;
  logic [NUM_IRQ-1:0] bitmap_q;
  logic               wait_q;
  logic [31:0]        base_addr;
  logic [CW-1:0]      slot;
  logic [31:0]        direct_pc;
  logic               base_wr;

  assign base_wr   = csr_we && !csr_sel;
  assign base_addr = {base_q, 2'b00};
  assign slot      = bitmap_q[trap_cause] ? trap_cause : '0;
  assign direct_pc = (trap_is_irq && mode_q == 2'b01) ? base_addr + (32'(trap_cause) << 2) : base_addr;
  assign csr_rdata = csr_sel ? 32'(bitmap_q) : {base_q, mode_q};
  assign busy      = wait_q;

  generate
    if (FIXED_BASE) begin : g_fixed_base
      assign base_q = BASE_RESET[31:2];
    end else begin : g_wr_base
      always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= BASE_RESET[31:2];
        else if (base_wr) base_q <= csr_wdata[31:2];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= RESET_MODE;
      bitmap_q <= '0;
    end else if (csr_we) begin
      if (!csr_sel && MODE_OK[csr_wdata[1:0]]) mode_q <= csr_wdata[1:0];
      if (csr_sel && SUP_TABLE) bitmap_q <= csr_wdata[NUM_IRQ-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q    <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      tgt_valid <= 1'b0;
      tgt_pc    <= '0;
    end else begin
      mem_req   <= 1'b0;
      tgt_valid <= 1'b0;
      if (!wait_q) begin
        if (trap_req) begin
          if (trap_is_irq && mode_q == 2'b11) begin
            wait_q   <= 1'b1;
            mem_req  <= 1'b1;
            mem_addr <= base_addr + (32'(slot) << 2);
          end else begin
            tgt_valid <= 1'b1;
            tgt_pc    <= direct_pc;
          end
        end
      end else if (mem_rsp_valid) begin
        wait_q    <= 1'b0;
        tgt_valid <= 1'b1;
        tgt_pc    <= mem_rsp_err ? base_addr : (mem_rsp_data & ~32'h1);
      end
    end
  end
endmodule

// File: rtl/trap_vec_gen_chk.sv
module trap_vec_gen_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csr_we,
  input logic          csr_sel,
  input logic [31:0]   csr_wdata,
  input logic [1:0]    mode,
  input logic [31:0]   base_addr,
  input logic          trap_req,
  input logic          trap_is_irq,
  input logic [CW-1:0] trap_cause,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_err,
  input logic [31:0]   mem_rsp_data,
  input logic          tgt_valid,
  input logic [31:0]   tgt_pc
);
  // R3
  single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !busy && mode == 2'b00) |=> (tgt_valid && tgt_pc == $past(base_addr)));

  // R4
  jump_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !busy && trap_is_irq && mode == 2'b01)
      |=> (tgt_valid && tgt_pc == $past(base_addr) + (32'($past(trap_cause)) << 2)));

  // R5
  reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && !csr_sel && csr_wdata[1:0] == 2'b10) |=> $stable(mode));

  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R7
  ptr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rsp_valid && !mem_rsp_err)
      |=> (tgt_valid && tgt_pc == ($past(mem_rsp_data) & ~32'h1)));

  // R8
  err_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rsp_valid && mem_rsp_err) |=> (tgt_valid && tgt_pc == $past(base_addr)));

  // R9
  sync_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !busy && !trap_is_irq) |=> (tgt_valid && !mem_req && tgt_pc == $past(base_addr)));

  // R11
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rsp_valid) |=> (!tgt_valid && !mem_req));
endmodule

bind trap_vec_gen trap_vec_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
  .mode(mode_q), .base_addr(base_addr), .trap_req(trap_req), .trap_is_irq(trap_is_irq),
  .trap_cause(trap_cause), .busy(busy), .mem_req(mem_req), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data), .tgt_valid(tgt_valid), .tgt_pc(tgt_pc)
);

// File: tb/sim_trap_vec_gen.sv
`timescale 1ns/1ps
module sim_trap_vec_gen;
  typedef struct {
    int          cyc;
    bit          is_mem;
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        csr_we = 0, csr_sel = 0, trap_req = 0, trap_is_irq = 0;
  logic [31:0] csr_wdata = 0, mem_rsp_data = 0;
  logic [3:0]  trap_cause = 0;
  logic        mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [31:0] csr_rdata, mem_addr, tgt_pc;
  logic        busy, mem_req, tgt_valid;

  logic        b_we = 0, b_sel = 0, b_trap = 0;
  logic [31:0] b_wdata = 0, b_rdata, b_addr, b_pc;
  logic        b_busy, b_req, b_valid;

  trap_vec_gen u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .trap_req(trap_req), .trap_is_irq(trap_is_irq), .trap_cause(trap_cause),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err), .tgt_valid(tgt_valid), .tgt_pc(tgt_pc)
  );

  trap_vec_gen #(.FIXED_BASE(1'b1), .BASE_RESET(32'h0000_0400), .SUP_VEC(1'b0), .SUP_TABLE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .csr_we(b_we), .csr_sel(b_sel), .csr_wdata(b_wdata),
    .csr_rdata(b_rdata), .trap_req(b_trap), .trap_is_irq(1'b1), .trap_cause(4'd6),
    .busy(b_busy), .mem_req(b_req), .mem_addr(b_addr), .mem_rsp_valid(1'b0),
    .mem_rsp_data(32'h0), .mem_rsp_err(1'b0), .tgt_valid(b_valid), .tgt_pc(b_pc)
  );

  int   cyc = 0, checks = 0, fails = 0;
  exp_t sb[$];
  exp_t e;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (mem_req || tgt_valid)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected output", mem_req ? mem_addr : tgt_pc, 32'h0);
      end else begin
        e = sb.pop_front();
        chk(e.is_mem == mem_req && e.cyc == cyc && (mem_req ? mem_addr : tgt_pc) == e.val,
            e.tag, mem_req ? mem_addr : tgt_pc, e.val);
      end
    end
  end

  task automatic wr(bit sel, logic [31:0] d);
    csr_we = 1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic rd(bit sel, logic [31:0] exp, string tag);
    csr_sel = sel; #1;
    chk(csr_rdata == exp, tag, csr_rdata, exp);
  endtask

  task automatic trap(bit irq, int c, bit is_mem, logic [31:0] v, string tag, bit expect_out);
    trap_req = 1; trap_is_irq = irq; trap_cause = c[3:0];
    if (expect_out) sb.push_back('{cyc + 1, is_mem, v, tag});
    @(negedge clk);
    trap_req = 0;
  endtask

  task automatic rsp(logic [31:0] d, bit err, logic [31:0] exp_pc, string tag);
    mem_rsp_valid = 1; mem_rsp_data = d; mem_rsp_err = err;
    sb.push_back('{cyc + 1, 1'b0, exp_pc, tag});
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_err = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, 32'h0000_1000, "R1 base after reset");
    rd(1, 32'h0, "R1 bitmap after reset");
    chk(!tgt_valid && !mem_req, "R1 outputs idle", {30'b0, tgt_valid, mem_req}, 32'h0);

    // R3 single-entry mode, back-to-back traps
    trap(0, 3, 0, 32'h0000_1000, "R3 sync", 1);
    trap(1, 7, 0, 32'h0000_1000, "R3 irq", 1);

    // R2, R4 jump-table mode
    wr(0, 32'h8000_0101);
    rd(0, 32'h8000_0101, "R2 base readback");
    trap(0, 9, 0, 32'h8000_0100, "R4 sync", 1);
    trap(1, 9, 0, 32'h8000_0124, "R4 irq 9", 1);
    trap(1, 15, 0, 32'h8000_013C, "R4 irq 15", 1);
    trap(1, 0, 0, 32'h8000_0100, "R4 irq 0", 1);

    // R5 reserved mode write keeps mode, base updates
    wr(0, 32'h0000_3002);
    rd(0, 32'h0000_3001, "R5 reserved mode");
    trap(1, 2, 0, 32'h0000_3008, "R5 still jump-table", 1);

    // R12 bitmap
    wr(0, 32'h0000_4003);
    rd(0, 32'h0000_4003, "R2 table mode readback");
    wr(1, 32'hFFFF_00A0);
    rd(1, 32'h0000_00A0, "R12 bitmap width");

    // R6, R7 own slot
    trap(1, 5, 1, 32'h0000_4014, "R6 own slot addr", 1);
    rsp(32'h1234_5679, 0, 32'h1234_5678, "R7 pointer bit0 cleared");
    // R6 shared slot, delayed response, R11 traps while busy
    trap(1, 6, 1, 32'h0000_4000, "R6 shared slot addr", 1);
    repeat (2) @(negedge clk);
    trap(1, 5, 0, 32'h0, "R11", 0);
    trap(0, 1, 0, 32'h0, "R11", 0);
    @(negedge clk);
    chk(busy, "R11 still busy", {31'b0, busy}, 32'h1);
    rsp(32'hABCD_0000, 0, 32'hABCD_0000, "R7 delayed response");
    // R8 bus error
    trap(1, 7, 1, 32'h0000_401C, "R6 slot 7 addr", 1);
    rsp(32'hDEAD_BEEF, 1, 32'h0000_4000, "R8 error to base");
    // R9 sync in table mode
    trap(0, 2, 0, 32'h0000_4000, "R9 sync no fetch", 1);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R7 all outputs seen", sb.size(), 32'h0);

    // R10 fixed base, reduced capabilities
    b_we = 1; b_sel = 0; b_wdata = 32'h1234_5679;
    @(negedge clk);
    b_we = 0; b_sel = 0; #1;
    chk(b_rdata == 32'h0000_0400, "R10 fixed base, unsupported mode 01", b_rdata, 32'h0000_0400);
    b_we = 1; b_wdata = 32'h0000_0003;
    @(negedge clk);
    b_we = 0; #1;
    chk(b_rdata == 32'h0000_0400, "R5 unsupported mode 11", b_rdata, 32'h0000_0400);
    b_we = 1; b_sel = 1; b_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    b_we = 0; #1;
    chk(b_rdata == 32'h0, "R12 no table support", b_rdata, 32'h0);
    b_trap = 1;
    @(negedge clk);
    b_trap = 0;
    chk(b_valid && b_pc == 32'h0000_0400 && !b_req, "R10 trap to fixed base", b_pc, 32'h0000_0400);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule